// File: doc/BRIEF.md
# Bidirectional Column Strobe Sequencer

This block produces the per-column sampling strobes for a 240-column display source driver. A cascade start pulse enters on one of two cascade pins and travels down a chain of 80 three-column groups, one group per period of the first clock phase. When the last group has been strobed, a carry pulse leaves on the other pin so that the next driver in a chain can begin its own scan. A direction input decides which pin is the start input, which pin carries out, and whether the scan runs from the first column to the last or the reverse.

The three shift clock phases are inputs sampled by the block's system clock, and each of their rising edges is one event. The pixel-array code picks the sampling style. For a stripe panel, all three columns of a group strobe together and only phase 1 matters. For the delta and mosaic panels, the three columns of a group strobe one after another, on the edges of phases 1, 2 and 3. Each cascade pin appears as an input, an output and an output enable, and a pad ring joins them into one bidirectional pin. The block has no data stream, so it has no valid/ready handshake.

Top module: `sample_strobe_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every group, lane and carry stage, so `strobe` and both cascade outputs are all zero after that edge.
- R2: The start level is taken from `cas_r_in` when `dir_fwd` is 1 and from `cas_l_in` when `dir_fwd` is 0. It is read only at a rising edge of `ph1`. The unselected pin, and any start level seen only at `ph2`/`ph3` edges, launch nothing.
- R3: The scan runs in order s = 0 to 239, with group g covering s = 3g, 3g+1, 3g+2. It drives `strobe[s]` when `dir_fwd` is 1 and `strobe[239-s]` when `dir_fwd` is 0.
- R4: With `arr_mode` = 2'b00 (stripe), the three strobes of a group rise together on a `ph1` rising edge and stay high until the next `ph1` rising edge. `ph2` and `ph3` have no effect.
- R5: With `arr_mode` = 2'b01, 2'b10 or 2'b11 (delta, mosaic, two-sided delta), lane 0 of a group rises on a `ph1` edge, lane 1 on the next `ph2` edge and lane 2 on the next `ph3` edge. Each lane stays high until the next rising edge of its own phase.
- R6: A scan is launched only when the start level at a `ph1` edge is 1 and it was 0 at the previous `ph1` edge. A start held high over several `ph1` edges launches exactly one scan.
- R7: The carry output is high for exactly the one `ph1` period that follows the period in which the last group was active. The carry goes out on `cas_l_out` when `dir_fwd` is 1 and on `cas_r_out` when `dir_fwd` is 0. The start pin's output stays 0 and its enable is low, and the carry pin's enable is high.
- R8: A phase held high for many system clocks counts as a single edge. The outputs change only in the clock after a phase goes from low to high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the phases |
| rst | input | 1 | Synchronous reset, active high |
| dir_fwd | input | 1 | 1: start on right pin, scan first to last column; 0: the reverse |
| arr_mode | input | 2 | Pixel-array code; 2'b00 selects simultaneous, any other value successive |
| ph1 | input | 1 | Shift clock phase 1 (start capture and group advance) |
| ph2 | input | 1 | Shift clock phase 2 (lane 1 in successive mode) |
| ph3 | input | 1 | Shift clock phase 3 (lane 2 in successive mode) |
| cas_r_in | input | 1 | Right cascade pin, input side |
| cas_r_out | output | 1 | Right cascade pin, output side |
| cas_r_oe | output | 1 | Right cascade pin output enable |
| cas_l_in | input | 1 | Left cascade pin, input side |
| cas_l_out | output | 1 | Left cascade pin, output side |
| cas_l_oe | output | 1 | Left cascade pin output enable |
| strobe | output | 240 | Per-column sampling strobes, bit index = column number minus one |

## Verification
The bench runs full scans in both directions and in both sampling styles, so that a design that reverses the column map or puts the carry on the wrong pin sends strobes to mirrored columns or pulses the input pin. In successive mode it checks the overlap after every phase edge, where lanes 1 and 2 of the previous group are still high while lane 0 of the new group is already up. A design that advanced all lanes together, or cleared them early, would miss that overlap. A start held over three `ph1` edges and a `ph1` held for six clocks catch designs that launch several tokens or advance on every clock. A start level on the wrong pin, or seen only at `ph2`/`ph3` edges, must launch nothing. A reset in the middle of a scan must leave no stale token.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int LANES = 3;

  typedef enum logic [1:0] {
    ARR_STRIPE = 2'b00,
    ARR_DELTA1 = 2'b01,
    ARR_MOSAIC = 2'b10,
    ARR_DELTA2 = 2'b11
  } arr_mode_e;

  // Only the stripe arrangement samples a whole group at once (R4/R5).
  function automatic logic uses_phases(input logic [1:0] code);
    return code != ARR_STRIPE;
  endfunction
endpackage

// File: rtl/phase_edge.sv
module phase_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ph,
  output logic [N-1:0] rise
);
  logic [N-1:0] ph_d;

  always_ff @(posedge clk) begin
    if (rst) ph_d <= '0;
    else     ph_d <= ph;
  end

  // One event per low-to-high change, however long the phase stays high (R8).
  assign rise = ph & ~ph_d;
endmodule

// File: rtl/token_chain.sv
module token_chain #(
  parameter int GROUPS = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              start_lvl,
  output logic [GROUPS-1:0] grp,
  output logic              carry
);
  logic start_prev;
  logic launch;

  // Only a fresh start launches a token, so stretching it is harmless (R6).
  assign launch = start_lvl & ~start_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp        <= '0;
      carry      <= 1'b0;
      start_prev <= 1'b0;
    end else if (adv) begin
      start_prev <= start_lvl;
      grp        <= {grp[GROUPS-2:0], launch};
      carry      <= grp[GROUPS-1];   // R7: one ph1 period after last group
    end
  end
endmodule

// File: rtl/lane_stager.sv
module lane_stager #(
  parameter int GROUPS = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              succ,
  input  logic              rise2,
  input  logic              rise3,
  input  logic [GROUPS-1:0] grp,
  output logic [GROUPS-1:0] lane1,
  output logic [GROUPS-1:0] lane2
);
  // R5: lane 1 follows the group token at ph2, lane 2 follows lane 1 at ph3.
  always_ff @(posedge clk) begin
    if (rst) begin
      lane1 <= '0;
      lane2 <= '0;
    end else begin
      if (rise2) lane1 <= succ ? grp : '0;
      if (rise3) lane2 <= succ ? lane1 : '0;
    end
  end
endmodule

// File: rtl/sample_strobe_shifter.sv
module sample_strobe_shifter #(
  parameter  int GROUPS = 80,
  localparam int COLS   = GROUPS * sss_pkg::LANES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dir_fwd,
  input  logic [1:0]      arr_mode,
  input  logic            ph1,
  input  logic            ph2,
  input  logic            ph3,
  input  logic            cas_r_in,
  output logic            cas_r_out,
  output logic            cas_r_oe,
  input  logic            cas_l_in,
  output logic            cas_l_out,
  output logic            cas_l_oe,
  output logic [COLS-1:0] strobe
);
  import sss_pkg::*;

  logic [2:0]        rise;
  logic              succ;
  logic              start_lvl;
  logic              carry;
  logic [GROUPS-1:0] grp;
  logic [GROUPS-1:0] lane1;
  logic [GROUPS-1:0] lane2;
  logic [COLS-1:0]   scan;

  assign succ      = uses_phases(arr_mode);
  assign start_lvl = dir_fwd ? cas_r_in : cas_l_in;   // R2

  phase_edge #(.N(3)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .ph   ({ph3, ph2, ph1}),
    .rise (rise)
  );

  token_chain #(.GROUPS(GROUPS)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .adv       (rise[0]),
    .start_lvl (start_lvl),
    .grp       (grp),
    .carry     (carry)
  );

  lane_stager #(.GROUPS(GROUPS)) u_lanes (
    .clk   (clk),
    .rst   (rst),
    .succ  (succ),
    .rise2 (rise[1]),
    .rise3 (rise[2]),
    .grp   (grp),
    .lane1 (lane1),
    .lane2 (lane2)
  );

  // Scan-order vector: R4 shares the group token across lanes, R5 stages it.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign scan[LANES*g]     = grp[g];
    assign scan[LANES*g + 1] = succ ? lane1[g] : grp[g];
    assign scan[LANES*g + 2] = succ ? lane2[g] : grp[g];
  end

  // R3: map scan position to column by direction.
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign strobe[c] = dir_fwd ? scan[c] : scan[COLS-1-c];
  end

  // R7: pin roles swap with direction.
  assign cas_l_oe  = dir_fwd;
  assign cas_r_oe  = ~dir_fwd;
  assign cas_l_out = dir_fwd & carry;
  assign cas_r_out = ~dir_fwd & carry;
endmodule

// File: rtl/sample_strobe_shifter_chk.sv
module sample_strobe_shifter_chk #(
  parameter int COLS = 240
) (
  input logic            clk,
  input logic            rst,
  input logic            dir_fwd,
  input logic [1:0]      arr_mode,
  input logic            ph1,
  input logic            ph2,
  input logic            ph3,
  input logic            cas_r_out,
  input logic            cas_r_oe,
  input logic            cas_l_out,
  input logic            cas_l_oe,
  input logic [COLS-1:0] strobe
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (strobe == '0 && !cas_r_out && !cas_l_out));

  a_r2_pin_roles: assert property (@(posedge clk) disable iff (rst)
    dir_fwd |-> (cas_l_oe && !cas_r_oe));

  a_r7_start_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    dir_fwd ? !cas_r_out : !cas_l_out);

  a_r4_whole_groups: assert property (@(posedge clk) disable iff (rst)
    (arr_mode == 2'b00) |-> ($countones(strobe) % 3 == 0));

  a_r8_hold_no_advance: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) &&
     $past(ph1) && $past(ph1, 2) && $past(ph2) == $past(ph2, 2) &&
     $past(ph3) == $past(ph3, 2) && $past(ph2) == 1'b0 && $past(ph3) == 1'b0 &&
     $stable(dir_fwd) && $stable(arr_mode)) |-> $stable(strobe));
endmodule

bind sample_strobe_shifter sample_strobe_shifter_chk #(.COLS(COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dir_fwd   (dir_fwd),
  .arr_mode  (arr_mode),
  .ph1       (ph1),
  .ph2       (ph2),
  .ph3       (ph3),
  .cas_r_out (cas_r_out),
  .cas_r_oe  (cas_r_oe),
  .cas_l_out (cas_l_out),
  .cas_l_oe  (cas_l_oe),
  .strobe    (strobe)
);

// File: tb/sample_strobe_shifter_tb.sv
module sample_strobe_shifter_tb;
  localparam int GROUPS = 80;
  localparam int COLS   = GROUPS * 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_fwd = 1'b1;
  logic [1:0] arr_mode = 2'b00;
  logic ph1 = 1'b0, ph2 = 1'b0, ph3 = 1'b0;
  logic cas_r_in = 1'b0, cas_l_in = 1'b0;
  logic cas_r_out, cas_r_oe, cas_l_out, cas_l_oe;
  logic [COLS-1:0] strobe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  sample_strobe_shifter #(.GROUPS(GROUPS)) u_dut (
    .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .arr_mode(arr_mode),
    .ph1(ph1), .ph2(ph2), .ph3(ph3),
    .cas_r_in(cas_r_in), .cas_r_out(cas_r_out), .cas_r_oe(cas_r_oe),
    .cas_l_in(cas_l_in), .cas_l_out(cas_l_out), .cas_l_oe(cas_l_oe),
    .strobe(strobe)
  );

  // Expected strobes for selected lanes of group g (scan s = 3g+lane).
  function automatic logic [COLS-1:0] lanes_of(int g, logic [2:0] m, logic fwd);
    logic [COLS-1:0] v = '0;
    if (g >= 0 && g < GROUPS)
      for (int l = 0; l < 3; l++)
        if (m[l]) v[fwd ? 3*g+l : COLS-1-(3*g+l)] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(string tag, logic [COLS-1:0] act, logic [COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Raise one phase for a clock, lower it; returns after the update is visible.
  task automatic pulse(int which);
    @(negedge clk);
    if (which == 1) ph1 = 1'b1; else if (which == 2) ph2 = 1'b1; else ph3 = 1'b1;
    @(negedge clk);
    ph1 = 1'b0; ph2 = 1'b0; ph3 = 1'b0;
  endtask

  task automatic do_reset(logic fwd, logic [1:0] mode);
    @(negedge clk);
    rst = 1'b1; dir_fwd = fwd; arr_mode = mode;
    cas_r_in = 1'b0; cas_l_in = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 2'b00);
    chk_vec("R1 strobes after reset", strobe, '0);
    chk_bit("R1 left carry after reset", cas_l_out, 1'b0);
    chk_bit("R1 right carry after reset", cas_r_out, 1'b0);
    chk_bit("R7 fwd left oe", cas_l_oe, 1'b1);
    chk_bit("R7 fwd right oe", cas_r_oe, 1'b0);
  endtask

  task automatic t_simul_scan(logic fwd);
    do_reset(fwd, 2'b00);
    chk_bit("R7 carry pin oe", fwd ? cas_l_oe : cas_r_oe, 1'b1);
    if (fwd) cas_r_in = 1'b1; else cas_l_in = 1'b1;
    pulse(1);
    cas_r_in = 1'b0; cas_l_in = 1'b0;
    chk_vec("R3 R4 first group", strobe, lanes_of(0, 3'b111, fwd));
    for (int g = 1; g < GROUPS; g++) begin
      pulse(2); pulse(3);
      chk_vec("R4 ph2/ph3 ignored", strobe, lanes_of(g-1, 3'b111, fwd));
      pulse(1);
      chk_vec("R3 R4 group advance", strobe, lanes_of(g, 3'b111, fwd));
    end
    chk_bit("R7 no carry during scan", fwd ? cas_l_out : cas_r_out, 1'b0);
    pulse(1);
    chk_vec("R3 scan finished", strobe, '0);
    chk_bit("R7 carry after last group", fwd ? cas_l_out : cas_r_out, 1'b1);
    chk_bit("R7 start pin quiet", fwd ? cas_r_out : cas_l_out, 1'b0);
    pulse(1);
    chk_bit("R7 carry one period", fwd ? cas_l_out : cas_r_out, 1'b0);
  endtask

  task automatic t_succ_scan(logic fwd, logic [1:0] mode, int ngroups);
    do_reset(fwd, mode);
    if (fwd) cas_r_in = 1'b1; else cas_l_in = 1'b1;
    pulse(1);
    cas_r_in = 1'b0; cas_l_in = 1'b0;
    chk_vec("R5 lane0 on ph1", strobe, lanes_of(0, 3'b001, fwd));
    pulse(2);
    chk_vec("R5 lane1 on ph2", strobe, lanes_of(0, 3'b011, fwd));
    pulse(3);
    chk_vec("R5 lane2 on ph3", strobe, lanes_of(0, 3'b111, fwd));
    for (int g = 1; g < ngroups; g++) begin
      pulse(1);
      chk_vec("R5 ph1 overlap", strobe, lanes_of(g, 3'b001, fwd) | lanes_of(g-1, 3'b110, fwd));
      pulse(2);
      chk_vec("R5 ph2 overlap", strobe, lanes_of(g, 3'b011, fwd) | lanes_of(g-1, 3'b100, fwd));
      pulse(3);
      chk_vec("R5 ph3 full group", strobe, lanes_of(g, 3'b111, fwd));
    end
    if (ngroups == GROUPS) begin
      pulse(1);
      chk_vec("R5 tail lanes", strobe, lanes_of(GROUPS-1, 3'b110, fwd));
      chk_bit("R7 succ carry", fwd ? cas_l_out : cas_r_out, 1'b1);
      pulse(2); pulse(3);
      chk_vec("R5 tail cleared", strobe, '0);
    end
  endtask

  task automatic t_stretched_start();
    do_reset(1'b1, 2'b00);
    cas_r_in = 1'b1;
    pulse(1); pulse(1); pulse(1);
    chk_vec("R6 held start gives one token", strobe, lanes_of(2, 3'b111, 1'b1));
    cas_r_in = 1'b0;
    pulse(1);
    chk_vec("R6 single token advances", strobe, lanes_of(3, 3'b111, 1'b1));
  endtask

  task automatic t_ignored_start();
    do_reset(1'b1, 2'b00);
    cas_l_in = 1'b1;
    pulse(1); pulse(1);
    chk_vec("R2 wrong pin ignored", strobe, '0);
    cas_l_in = 1'b0;
    cas_r_in = 1'b1;
    pulse(2); pulse(3);
    cas_r_in = 1'b0;
    pulse(1);
    chk_vec("R2 start only read at ph1", strobe, '0);
  endtask

  task automatic t_long_phase();
    do_reset(1'b1, 2'b00);
    cas_r_in = 1'b1;
    pulse(1);
    cas_r_in = 1'b0;
    @(negedge clk);
    ph1 = 1'b1;
    repeat (6) @(negedge clk);
    ph1 = 1'b0;
    chk_vec("R8 long ph1 one step", strobe, lanes_of(1, 3'b111, 1'b1));
  endtask

  task automatic t_mid_reset();
    do_reset(1'b1, 2'b01);
    cas_r_in = 1'b1;
    pulse(1);
    cas_r_in = 1'b0;
    pulse(2); pulse(3); pulse(1); pulse(2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_vec("R1 mid-scan reset", strobe, '0);
    pulse(1); pulse(2); pulse(3);
    chk_vec("R1 no stale token", strobe, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_simul_scan(1'b1);
    t_simul_scan(1'b0);
    t_succ_scan(1'b1, 2'b01, GROUPS);
    t_succ_scan(1'b0, 2'b10, 4);
    t_succ_scan(1'b1, 2'b11, 3);
    t_stretched_start();
    t_ignored_start();
    t_long_phase();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule